// File: doc/BRIEF.md
# Lockable Victim Way Selector

This block picks which way of a 64-way set-associative cache receives the next line fill after a miss. The cache controller raises a one-cycle miss strobe when an eight-word fill is about to start. One clock later the selector returns a way index with a one-cycle valid pulse. A mode input picks the policy at the moment of the miss. When it is high, a rotating pointer hands out ways in ascending order. When it is low, a free-running linear feedback shift register supplies a pseudo-random way.

A lockdown base input protects the lowest-numbered ways. Every way below the base is reserved and is never returned, so the contents of those ways survive every fill. The base can be any value from 0 to 63, one way at a time. When the base is 63, way 63 is the only replaceable way. If the base is raised past the rotating pointer, the pointer jumps up to the base. If the base is lowered, the pointer keeps its place.

The control path is a two-state machine. The states are `ST_IDLE` (no grant pending) and `ST_GRANT` (victim output valid). The transition IDLE→GRANT and the transition GRANT→GRANT both happen on a miss. The transition GRANT→IDLE and the transition IDLE→IDLE both happen on a cycle without a miss.

Top module: `victim_way_sel`

## Requirements
- R1: After reset, `victim_valid_o` is 0. The first round-robin miss returns way `lock_base_i`.
- R2: A miss sampled at clock edge k raises `victim_valid_o` for exactly the cycle after edge k. The valid output is never high unless a miss was sampled at the previous edge.
- R3: Every victim returned is at least the value of `lock_base_i` sampled with the miss. No way below the base is ever returned.
- R4: In round-robin mode (`rr_mode_i`=1), consecutive misses return ascending ways, one step per miss. Cycles without a miss do not move the pointer.
- R5: In round-robin mode, after way 63 the next victim is way `lock_base_i`.
- R6: If `lock_base_i` rises above the rotating pointer, the next round-robin victim is the new base.
- R7: If `lock_base_i` drops below the rotating pointer, the pointer keeps its position.
- R8: In pseudo-random mode (`rr_mode_i`=0), victims lie in [base, 63]. With base 0, 200 misses cover at least 16 distinct ways.
- R9: Pseudo-random misses leave the rotating pointer unchanged. Round-robin resumes where it stopped.
- R10: With `lock_base_i`=63, every victim is way 63 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miss_i | input | 1 | One-cycle strobe: a line fill needs a victim |
| rr_mode_i | input | 1 | 1 = round-robin, 0 = pseudo-random; sampled with the miss |
| lock_base_i | input | 6 | Number of locked ways; ways below this value are reserved |
| victim_valid_o | output | 1 | Victim index valid for one cycle |
| victim_o | output | 6 | Way chosen for the fill |

## Verification
A pointer stuck, skipping, or failing to wrap shows up on the first round-robin miss that uses it. The bench catches it because it compares every victim with base plus the miss count modulo the unlocked span. A wrong lock clamp returns a reserved way on the first miss after the base is raised, and a stale pointer shows the same symptom. A wrong valid timing or a dropped pulse shows up one cycle after the strobe. Sweeps over several bases and over idle gaps between misses cover these cases. A weak or stuck random source shows as out-of-range ways or too few distinct ways within 200 misses.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } vsel_state_e;
endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [WIDTH-1:0] state_o
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS[WIDTH-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SEED[WIDTH-1:0];
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R8: a zero state would freeze the random source
    p_lfsr_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);
endmodule

// File: rtl/vsel_rr_ptr.sv
module vsel_rr_ptr #(
    parameter int NUM_WAYS = 64,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WAY_W-1:0] base_i,
    input  logic             adv_i,
    output logic [WAY_W-1:0] way_o
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

    logic [WAY_W-1:0] ptr_q;
    logic [WAY_W-1:0] eff_ptr;
    logic [WAY_W-1:0] ptr_d;

    always_comb begin
        eff_ptr = (ptr_q < base_i) ? base_i : ptr_q;
        if (adv_i) begin
            ptr_d = (eff_ptr == LAST) ? base_i : eff_ptr + 1'b1;
        end else begin
            ptr_d = eff_ptr;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign way_o = eff_ptr;

    // R5: the pointer wraps from the top way back to the base
    p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && way_o == LAST) |=> ptr_q == $past(base_i));

    // R4: a non-wrapping advance moves the pointer by one
    p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && way_o != LAST) |=> ptr_q == $past(way_o) + 1'b1);

    // R9: no advance keeps the pointer where it stands
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> ptr_q == $past(way_o));
endmodule

// File: rtl/vsel_fold.sv
module vsel_fold #(
    parameter int NUM_WAYS = 64,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [WAY_W-1:0] raw_i,
    input  logic [WAY_W-1:0] base_i,
    output logic [WAY_W-1:0] way_o
);
    localparam logic [WAY_W:0] N_EXT = (WAY_W+1)'(NUM_WAYS);

    logic [WAY_W:0] shifted;

    always_comb begin
        shifted = {1'b0, raw_i} + (N_EXT - {1'b0, base_i});
        if (raw_i >= base_i) begin
            way_o = raw_i;
        end else if (shifted[WAY_W-1:0] >= base_i) begin
            way_o = shifted[WAY_W-1:0];
        end else begin
            way_o = base_i;
        end
    end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
    import victim_sel_pkg::*;
#(
    parameter int NUM_WAYS = 64,
    parameter int LFSR_W   = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             miss_i,
    input  logic             rr_mode_i,
    input  logic [WAY_W-1:0] lock_base_i,
    output logic             victim_valid_o,
    output logic [WAY_W-1:0] victim_o
);
    vsel_state_e      state_q;
    vsel_state_e      state_d;
    logic [WAY_W-1:0] rr_way;
    logic [WAY_W-1:0] rnd_way;
    logic [LFSR_W-1:0] lfsr_state;
    logic [WAY_W-1:0] victim_q;

    vsel_rr_ptr #(.NUM_WAYS(NUM_WAYS)) u_ptr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .base_i (lock_base_i),
        .adv_i  (miss_i & rr_mode_i),
        .way_o  (rr_way)
    );

    vsel_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_o (lfsr_state)
    );

    vsel_fold #(.NUM_WAYS(NUM_WAYS)) u_fold (
        .raw_i  (lfsr_state[WAY_W-1:0]),
        .base_i (lock_base_i),
        .way_o  (rnd_way)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = miss_i ? ST_GRANT : ST_IDLE;
            ST_GRANT: state_d = miss_i ? ST_GRANT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            victim_q <= '0;
        end else if (miss_i) begin
            victim_q <= rr_mode_i ? rr_way : rnd_way;
        end
    end

    assign victim_valid_o = (state_q == ST_GRANT);
    assign victim_o       = victim_q;

    // R2: a valid pulse always follows a sampled miss
    p_valid_after_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        victim_valid_o |-> $past(miss_i));

    // R2: a sampled miss always yields a valid pulse
    p_miss_gives_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_i |=> victim_valid_o);

    // R3: a granted way is never below the base seen with the miss
    p_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        victim_valid_o |-> victim_o >= $past(lock_base_i));

    // R3: the random path alone already respects the lock
    p_rnd_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_way >= lock_base_i);
endmodule

// File: tb/tb_victim_way_sel.sv
module tb_victim_way_sel;
    localparam int N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss = 1'b0;
    logic       rr_mode = 1'b1;
    logic [5:0] base = '0;
    logic       vld;
    logic [5:0] way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    victim_way_sel dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .miss_i         (miss),
        .rr_mode_i      (rr_mode),
        .lock_base_i    (base),
        .victim_valid_o (vld),
        .victim_o       (way)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int b);
        @(negedge clk);
        rst_n = 1'b0;
        miss = 1'b0;
        base = 6'(b);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one miss and return the granted way; idle cycles follow
    task automatic do_miss(input bit mode, input int gap, output int got);
        rr_mode = mode;
        miss = 1'b1;
        @(negedge clk);
        miss = 1'b0;
        check("R2 valid after miss", int'(vld), 1);
        got = int'(way);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check("R2 valid drops", int'(vld), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int got;
        int bases [5] = '{0, 1, 31, 62, 63};

        // R1 reset state
        do_reset(9);
        check("R1 valid low after reset", int'(vld), 0);
        do_miss(1'b1, 1, got);
        check("R1 first victim is base", got, 9);

        // R4 R5 R3 round-robin sweep over several bases
        foreach (bases[k]) begin
            int b = bases[k];
            int span = N - b;
            do_reset(b);
            for (int i = 0; i < 2 * span + 3; i++) begin
                do_miss(1'b1, i % 3, got);
                check("R4 R5 round-robin order", got, b + (i % span));
                checks++;
                if (got < b) begin
                    failures++;
                    $display("FAIL R3 locked way actual=%0d expected>=%0d", got, b);
                end
            end
        end

        // R6 raise base above pointer, R7 lower base below pointer
        do_reset(0);
        for (int i = 0; i < 5; i++) begin
            do_miss(1'b1, 0, got);
        end
        check("R4 fifth victim", got, 4);
        base = 6'd20;
        @(negedge clk);
        do_miss(1'b1, 0, got);
        check("R6 jump to raised base", got, 20);
        base = 6'd5;
        do_miss(1'b1, 0, got);
        check("R7 pointer kept after base lowered", got, 21);

        // R9 random misses leave the rotating pointer alone
        for (int i = 0; i < 7; i++) begin
            do_miss(1'b0, 1, got);
        end
        do_miss(1'b1, 0, got);
        check("R9 round-robin resumes", got, 22);

        // R8 random range and spread
        begin
            logic [63:0] seen = '0;
            base = 6'd0;
            for (int i = 0; i < 200; i++) begin
                do_miss(1'b0, i % 2, got);
                seen[got] = 1'b1;
            end
            checks++;
            if ($countones(seen) < 16) begin
                failures++;
                $display("FAIL R8 distinct actual=%0d expected>=16", $countones(seen));
            end
        end
        base = 6'd40;
        for (int i = 0; i < 100; i++) begin
            do_miss(1'b0, 0, got);
            checks++;
            if (got < 40) begin
                failures++;
                $display("FAIL R8 R3 random below base actual=%0d expected>=40", got);
            end
        end

        // R10 single unlocked way
        base = 6'd63;
        for (int i = 0; i < 20; i++) begin
            do_miss(1'(i % 2), 0, got);
            check("R10 only way 63", got, 63);
        end

        @(negedge clk);
        check("R2 idle after last miss", int'(vld), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule